// File: doc/BRIEF.md
# Link Bandwidth Change Status Tracker

This block follows the speed of one switch port's link and keeps the sticky bandwidth-management status bit that software reads after a speed change. A link training state machine feeds it single-cycle event strobes. One reports a speed change, with its cause and the new rate. One reports the result of a retrain through Recovery. One reports entry into Detect, and one reports that the data link is up again. Software reaches it through a control write and a status write. The control write carries a retrain request, a full-retrain request and an interrupt enable. The status write clears the status bit by writing a one to it.

Only some speed changes are worth reporting. A downgrade made by the port itself counts, and so does a change that the link partner directs. A retrain requested by software always counts, even when the rate stays the same. Some changes are not reported: fallbacks from failed upgrade attempts, autonomous changes by the partner, and changes made while the link is still in its first training after reset or after Detect. The block also holds the rate policy. After a downgrade the port stays at Gen1 until the partner asks for Gen2, or until software requests a retrain or a full retrain. A full retrain sends the training state machine to Detect and marks the data link down, and it leaves the status bit as it is.

Top module: `lbw_status_tracker`

## Requirements
- R1: After reset, cur_rate is 0 (Gen1; 1 means Gen2), bw_status, irq, recovery_req and detect_req are 0, dl_down is 1, and the initial-training window is open.
- R2: On ev_speed_chg, cur_rate takes ev_new_rate in the next cycle unless the event is blocked by R9. ev_cause encodes the cause: 0 = the port downgraded because the higher rate is unreliable, 1 = an upgrade attempt fell back because symbol lock was not reached, 2 = the partner directed the change without marking it autonomous, 3 = the partner changed the rate autonomously.
- R3: An accepted speed change that alters the rate sets bw_status in the next cycle only for cause 0 with a move to Gen1, or for cause 2. Cause 1 and cause 3 never set it.
- R4: The initial-training window opens at reset and at ev_detect. It closes at the first accepted ev_speed_chg or at the first ev_retrain_done. No event handled while the window is open sets bw_status.
- R5: A control write with bit 0 set makes recovery_req 1 for exactly the next cycle. It sets bw_status even when the rate does not change, and it lifts the Gen1 hold.
- R6: A control write with bit 1 set makes detect_req 1 for exactly the next cycle and dl_down 1 from the next cycle. It lifts the Gen1 hold and leaves bw_status unchanged.
- R7: ev_detect sets cur_rate to Gen1, sets dl_down and lifts the Gen1 hold. ev_link_up clears dl_down.
- R8: ev_retrain_done with ev_retrain_ok=1 keeps cur_rate. With ev_retrain_ok=0 at Gen2, the rate drops to Gen1, the Gen1 hold is set and bw_status is set (outside the R4 window). With ev_retrain_ok=0 at Gen1, nothing changes.
- R9: The Gen1 hold is set by a cause-0 downgrade and by a failed retrain. While it holds, an ev_speed_chg to Gen2 with cause 0 or 1 is ignored. A move to Gen2 with cause 2 or 3 is accepted and lifts the hold.
- R10: A status write with sts_w1c=1 clears bw_status in the next cycle. A set in the same cycle wins over the clear, and sts_w1c=0 has no effect.
- R11: irq equals bw_status AND the interrupt enable. The interrupt enable is loaded from bit 2 of every control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_speed_chg | input | 1 | Speed change event strobe |
| ev_cause | input | 2 | Cause of the speed change (R2 encoding) |
| ev_new_rate | input | 1 | New rate: 0 Gen1, 1 Gen2 |
| ev_retrain_done | input | 1 | Retrain result strobe |
| ev_retrain_ok | input | 1 | Retrain kept the current rate |
| ev_detect | input | 1 | Training state machine entered Detect |
| ev_link_up | input | 1 | Data link came back up |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | bit0 retrain, bit1 full retrain, bit2 interrupt enable |
| sts_wr | input | 1 | Status register write strobe |
| sts_w1c | input | 1 | Write-one-to-clear value for the status bit |
| cur_rate | output | 1 | Current rate: 0 Gen1, 1 Gen2 |
| bw_status | output | 1 | Sticky bandwidth-management status |
| irq | output | 1 | Interrupt request |
| recovery_req | output | 1 | One-cycle request to retrain through Recovery |
| detect_req | output | 1 | One-cycle request to go to Detect |
| dl_down | output | 1 | Data link is down |

## Verification
The properties assume that the training state machine raises at most one of ev_speed_chg, ev_retrain_done and ev_detect in any one cycle. Where the inputs do overlap, the design resolves them in the order Detect, then retrain result, then speed change. The properties about status stability leave out the cycles in which a software retrain or a status write falls together with the event under test. The bench drives one event per cycle and starts each sweep point from a state reached through legal event sequences. It steps through every combination of cause, target rate and starting state (initial window, Gen2, held at Gen1).

// File: rtl/lbw_pkg.sv
package lbw_pkg;
  typedef enum logic [1:0] {
    CAUSE_LOCAL_DOWN    = 2'd0,
    CAUSE_UPG_FALLBACK  = 2'd1,
    CAUSE_PEER_DIRECTED = 2'd2,
    CAUSE_PEER_AUTO     = 2'd3
  } chg_cause_e;

  typedef enum logic {
    RATE_GEN1 = 1'b0,
    RATE_GEN2 = 1'b1
  } rate_e;

  localparam int CAUSE_W     = 2;
  localparam int CTL_W       = 3;
  localparam int CTL_RETRAIN = 0;
  localparam int CTL_FULL    = 1;
  localparam int CTL_IEN     = 2;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/lbw_rst_sync.sv
module lbw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lbw_ctl_regs.sv
module lbw_ctl_regs
  import lbw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             sw_retrain,
  output logic             sw_full,
  output logic             retrain_q,
  output logic             full_q,
  output logic             ien_q
);
  logic retrain_d, full_d, ien_d, ien_en;

  assign sw_retrain = ctl_wr & ctl_wdata[CTL_RETRAIN];
  assign sw_full    = ctl_wr & ctl_wdata[CTL_FULL];
  assign ien_en     = ctl_wr;

  // command bits self-clear one cycle after the write
  always_comb begin
    retrain_d = sw_retrain;
    full_d    = sw_full;
    ien_d     = ctl_wdata[CTL_IEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retrain_q <= 1'b0;
      full_q    <= 1'b0;
    end else begin
      retrain_q <= retrain_d;
      full_q    <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= 1'b0;
    else if (ien_en) ien_q <= ien_d;
  end
endmodule

// File: rtl/lbw_rate_policy.sv
module lbw_rate_policy
  import lbw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_speed_chg,
  input  logic [CAUSE_W-1:0] ev_cause,
  input  logic               ev_new_rate,
  input  logic               ev_retrain_done,
  input  logic               ev_retrain_ok,
  input  logic               ev_detect,
  input  logic               sw_retrain,
  input  logic               sw_full,
  output logic               cur_rate,
  output logic               status_set
);
  rate_e      rate_q, rate_d;
  logic       hold_q, hold_d;
  logic       init_q, init_d;
  chg_cause_e cause;
  rate_e      target;
  logic       peer, blocked, local_down;

  assign cause      = chg_cause_e'(ev_cause);
  assign target     = rate_e'(ev_new_rate);
  assign peer       = (cause == CAUSE_PEER_DIRECTED) || (cause == CAUSE_PEER_AUTO);
  assign blocked    = hold_q && (target == RATE_GEN2) && !peer;
  assign local_down = (cause == CAUSE_LOCAL_DOWN) && (target == RATE_GEN1);

  always_comb begin
    rate_d     = rate_q;
    hold_d     = hold_q;
    init_d     = init_q;
    status_set = 1'b0;
    if (sw_retrain || sw_full) hold_d = 1'b0;
    if (ev_detect) begin
      rate_d = RATE_GEN1;
      hold_d = 1'b0;
      init_d = 1'b1;
    end else if (ev_retrain_done) begin
      init_d = 1'b0;
      if (!ev_retrain_ok && rate_q == RATE_GEN2) begin
        rate_d     = RATE_GEN1;
        hold_d     = 1'b1;
        status_set = !init_q;
      end
    end else if (ev_speed_chg && !blocked) begin
      init_d = 1'b0;
      if (target != rate_q) begin
        rate_d = target;
        if (peer && target == RATE_GEN2) hold_d = 1'b0;
        if (local_down) hold_d = 1'b1;
        status_set = !init_q && (local_down || cause == CAUSE_PEER_DIRECTED);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_GEN1;
      hold_q <= 1'b0;
      init_q <= 1'b1;
    end else begin
      rate_q <= rate_d;
      hold_q <= hold_d;
      init_q <= init_d;
    end
  end

  assign cur_rate = rate_q;
endmodule

// File: rtl/lbw_status_reg.sv
module lbw_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_set,
  input  logic sw_retrain,
  input  logic clr,
  input  logic ien,
  input  logic link_down_set,
  input  logic link_up,
  output logic status,
  output logic irq,
  output logic dl_down
);
  logic status_d, set_any, status_en;
  logic dl_d, dl_en;

  assign set_any   = ev_set | sw_retrain;
  assign status_en = set_any | clr;
  assign dl_en     = link_down_set | link_up;

  // a set in the same cycle wins over the clear
  always_comb begin
    status_d = set_any;
    dl_d     = link_down_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= 1'b0;
    else if (status_en) status <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dl_down <= 1'b1;
    else if (dl_en) dl_down <= dl_d;
  end

  assign irq = status & ien;
endmodule

// File: rtl/lbw_status_tracker.sv
module lbw_status_tracker
  import lbw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_speed_chg,
  input  logic [CAUSE_W-1:0] ev_cause,
  input  logic               ev_new_rate,
  input  logic               ev_retrain_done,
  input  logic               ev_retrain_ok,
  input  logic               ev_detect,
  input  logic               ev_link_up,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               sts_wr,
  input  logic               sts_w1c,
  output logic               cur_rate,
  output logic               bw_status,
  output logic               irq,
  output logic               recovery_req,
  output logic               detect_req,
  output logic               dl_down
);
  logic rst_sync_n;
  logic sw_retrain, sw_full, ien_q;
  logic status_set;

  lbw_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lbw_ctl_regs i_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .sw_retrain (sw_retrain),
    .sw_full    (sw_full),
    .retrain_q  (recovery_req),
    .full_q     (detect_req),
    .ien_q      (ien_q)
  );

  lbw_rate_policy i_policy (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .ev_speed_chg    (ev_speed_chg),
    .ev_cause        (ev_cause),
    .ev_new_rate     (ev_new_rate),
    .ev_retrain_done (ev_retrain_done),
    .ev_retrain_ok   (ev_retrain_ok),
    .ev_detect       (ev_detect),
    .sw_retrain      (sw_retrain),
    .sw_full         (sw_full),
    .cur_rate        (cur_rate),
    .status_set      (status_set)
  );

  lbw_status_reg i_status (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .ev_set        (status_set),
    .sw_retrain    (sw_retrain),
    .clr           (sts_wr & sts_w1c),
    .ien           (ien_q),
    .link_down_set (sw_full | ev_detect),
    .link_up       (ev_link_up),
    .status        (bw_status),
    .irq           (irq),
    .dl_down       (dl_down)
  );
endmodule

// File: rtl/lbw_checker.sv
module lbw_checker
  import lbw_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ev_speed_chg,
  input logic [CAUSE_W-1:0] ev_cause,
  input logic               ev_retrain_done,
  input logic               ev_retrain_ok,
  input logic               ev_detect,
  input logic               ctl_wr,
  input logic [CTL_W-1:0]   ctl_wdata,
  input logic               sts_wr,
  input logic               sts_w1c,
  input logic               cur_rate,
  input logic               bw_status,
  input logic               irq,
  input logic               recovery_req,
  input logic               detect_req,
  input logic               dl_down
);
  logic no_sw_set;
  assign no_sw_set = !(ctl_wr && ctl_wdata[CTL_RETRAIN]);

  // R5
  recovery_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_req |=> !recovery_req);
  // R6
  detect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_req |=> !detect_req);
  // R6
  detect_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_req |-> dl_down);
  // R6
  full_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[CTL_FULL] && no_sw_set && !sts_wr && !ev_speed_chg
     && !ev_retrain_done && !ev_detect) |=> $stable(bw_status));
  // R3
  fallback_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_speed_chg && ev_cause == CAUSE_UPG_FALLBACK && !ev_detect && !ev_retrain_done
     && no_sw_set && !bw_status) |=> !bw_status);
  // R7
  detect_gen1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_detect |=> (cur_rate == RATE_GEN1) && dl_down);
  // R8
  retrain_ok_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_retrain_done && ev_retrain_ok && !ev_detect) |=> $stable(cur_rate));
  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && sts_w1c && no_sw_set && !ev_speed_chg && !ev_retrain_done) |=> !bw_status);
  // R11
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> bw_status);
endmodule

bind lbw_status_tracker lbw_checker i_lbw_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .ev_speed_chg    (ev_speed_chg),
  .ev_cause        (ev_cause),
  .ev_retrain_done (ev_retrain_done),
  .ev_retrain_ok   (ev_retrain_ok),
  .ev_detect       (ev_detect),
  .ctl_wr          (ctl_wr),
  .ctl_wdata       (ctl_wdata),
  .sts_wr          (sts_wr),
  .sts_w1c         (sts_w1c),
  .cur_rate        (cur_rate),
  .bw_status       (bw_status),
  .irq             (irq),
  .recovery_req    (recovery_req),
  .detect_req      (detect_req),
  .dl_down         (dl_down)
);

// File: tb/test_lbw_status_tracker.sv
`timescale 1ns/1ps
module test_lbw_status_tracker;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_speed_chg, ev_new_rate, ev_retrain_done, ev_retrain_ok, ev_detect, ev_link_up;
  logic [1:0] ev_cause;
  logic ctl_wr, sts_wr, sts_w1c;
  logic [2:0] ctl_wdata;
  logic cur_rate, bw_status, irq, recovery_req, detect_req, dl_down;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of the requirements
  logic m_rate, m_hold, m_init, m_sts, m_ien, m_dl, m_rec, m_det;

  always #2 clk = ~clk;

  lbw_status_tracker i_lbw_status_tracker (.*);

  task automatic chk(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_speed_chg = 0; ev_cause = 0; ev_new_rate = 0; ev_retrain_done = 0;
    ev_retrain_ok = 0; ev_detect = 0; ev_link_up = 0;
    ctl_wr = 0; ctl_wdata = 0; sts_wr = 0; sts_w1c = 0;
  endtask

  task automatic tick(string tag);
    @(posedge clk); #1;
    chk(tag, "cur_rate", cur_rate, m_rate);
    chk(tag, "bw_status", bw_status, m_sts);
    chk(tag, "irq", irq, m_sts & m_ien);
    chk(tag, "dl_down", dl_down, m_dl);
    chk(tag, "recovery_req", recovery_req, m_rec);
    chk(tag, "detect_req", detect_req, m_det);
    idle_inputs();
    m_rec = 0; m_det = 0;
  endtask

  task automatic do_speed(string tag, logic [1:0] c, logic n);
    logic peer, blocked, set;
    ev_speed_chg = 1; ev_cause = c; ev_new_rate = n;
    peer = (c >= 2);
    blocked = m_hold && n && !peer;
    if (!blocked) begin
      set = !m_init && (n != m_rate) && ((c == 0 && !n) || c == 2);
      if (n != m_rate) begin
        if (n && peer) m_hold = 0;
        if (c == 0 && !n) m_hold = 1;
      end
      m_rate = n; m_init = 0;
      if (set) m_sts = 1;
    end
    tick(tag);
  endtask

  task automatic do_retrain_res(string tag, logic ok);
    ev_retrain_done = 1; ev_retrain_ok = ok;
    if (!ok && m_rate) begin
      m_rate = 0; m_hold = 1;
      if (!m_init) m_sts = 1;
    end
    m_init = 0;
    tick(tag);
  endtask

  task automatic do_detect(string tag);
    ev_detect = 1;
    m_rate = 0; m_hold = 0; m_init = 1; m_dl = 1;
    tick(tag);
  endtask

  task automatic do_link_up(string tag);
    ev_link_up = 1; m_dl = 0;
    tick(tag);
  endtask

  task automatic do_ctl(string tag, logic [2:0] w);
    ctl_wr = 1; ctl_wdata = w;
    m_ien = w[2];
    if (w[0]) begin m_sts = 1; m_hold = 0; m_rec = 1; end
    if (w[1]) begin m_hold = 0; m_det = 1; m_dl = 1; end
    tick(tag);
  endtask

  task automatic do_sts(string tag, logic v, logic [2:0] ctl_also);
    sts_wr = 1; sts_w1c = v;
    if (ctl_also != 0) begin
      ctl_wr = 1; ctl_wdata = ctl_also; m_ien = ctl_also[2];
      if (ctl_also[0]) begin m_rec = 1; m_hold = 0; end
    end
    if (v) m_sts = 0;
    if (ctl_also[0]) m_sts = 1;
    tick(tag);
  endtask

  task automatic setup_state(int s);
    do_detect("R7");
    do_link_up("R7");
    case (s)
      1: do_retrain_res("R4", 1'b1);
      2: do_speed("R2", 2'd3, 1'b1);
      3: begin do_speed("R2", 2'd3, 1'b1); do_retrain_res("R8", 1'b0); end
      default: ;
    endcase
    do_sts("R10", 1'b1, 3'b000);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    m_rate = 0; m_hold = 0; m_init = 1; m_sts = 0; m_ien = 0; m_dl = 1; m_rec = 0; m_det = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    tick("R1");

    // initial window: first upgrade does not set status
    do_link_up("R7");
    do_speed("R4", 2'd2, 1'b1);

    // sweep: starting states x causes x target rates
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++)
        for (int n = 0; n < 2; n++) begin
          setup_state(s);
          do_speed("R3", c[1:0], n[0]);
          // a second move back to Gen2 exercises the hold
          do_speed("R9", c[1:0], 1'b1);
        end

    // retrain results
    setup_state(2);
    do_retrain_res("R8", 1'b1);
    do_retrain_res("R8", 1'b0);
    do_sts("R10", 1'b1, 3'b000);
    do_retrain_res("R8", 1'b0);

    // software retrain sets status without a rate change, lifts hold
    setup_state(3);
    do_ctl("R5", 3'b001);
    tick("R5");
    do_speed("R9", 2'd0, 1'b1);

    // interrupt enable
    do_ctl("R11", 3'b100);
    do_ctl("R11", 3'b000);
    do_ctl("R11", 3'b100);
    do_sts("R11", 1'b1, 3'b000);

    // W1C priorities
    do_ctl("R10", 3'b101);
    do_sts("R10", 1'b0, 3'b000);
    do_sts("R10", 1'b1, 3'b101);
    do_sts("R10", 1'b1, 3'b000);

    // full retrain leaves status, pulses detect request, takes the link down
    setup_state(3);
    do_ctl("R6", 3'b010);
    tick("R6");
    do_speed("R6", 2'd1, 1'b1);
    do_ctl("R5", 3'b001);
    do_link_up("R7");
    do_ctl("R6", 3'b010);
    do_detect("R7");
    do_speed("R4", 2'd2, 1'b1);
    do_link_up("R7");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule